// File: doc/BRIEF.md
# UART Modem Control and Local Loopback

This block sits beside the transmitter and receiver of a UART. It holds the modem control register and drives the active-low DTR and RTS pins from it. It also keeps the two auxiliary control levels, AUX1 and AUX2, which never leave the chip. The external modem handshake inputs and the serial receive pin pass through a two-flop synchronizer before use. From them the block builds the modem status that the rest of the UART sees. It also keeps sticky change flags that the interrupt logic samples.

When the loop bit of the control register is set, the block becomes a diagnostic loopback:

- The transmit pin rests at marking (1), and the receive pin is disregarded.
- The transmit shift output feeds the receive shift input directly.
- The DTR and RTS pins are parked inactive.
- The status lines take their values from the low four control bits. DTR becomes DSR, RTS becomes CTS, AUX1 becomes RI and AUX2 becomes DCD.
- The change flags keep working in this mode, so software can raise modem interrupts from the control register alone.

Turning the loop bit on or off is never reported as a line change by itself.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the control register reads 0x00, dtr_n_pin and rts_n_pin are 1, msr_rdata is 0x00 (external inputs idle high) and ms_irq is 0.
- R2: A write with reg_wr stores reg_wdata[4:0] into the control register, visible on ctl_rdata from the next cycle. ctl_rdata[7:5] always read 0. Bit 0=DTR, 1=RTS, 2=AUX1, 3=AUX2, 4=loop.
- R3: With loop clear, dtr_n_pin equals the inverse of bit 0 and rts_n_pin equals the inverse of bit 1. A 1 in the register drives the pin low.
- R4: With loop set, dtr_n_pin, rts_n_pin and txd_pin are all 1, whatever the other register bits.
- R5: With loop clear, txd_pin follows tx_shift_out combinationally. rx_shift_in equals rxd_pin as it was two clock edges earlier.
- R6: With loop set, rx_shift_in equals tx_shift_out in the same cycle, and rxd_pin has no effect.
- R7: With loop clear, msr_rdata[7:4] = {DCD, RI, DSR, CTS}, each the inverse of its pin. This is visible after the third rising edge following a pin change.
- R8: With loop set, msr_rdata[7:4] = {bit3, bit2, bit0, bit1} of the control register, one cycle after the register changes. The external modem pins have no effect.
- R9: The flags msr_rdata[0] (CTS), [1] (DSR) and [3] (DCD) set on any change of their status line. msr_rdata[2] sets only when RI goes from asserted to deasserted. All four flags stay set until read.
- R10: A cycle with msr_rd high clears the flags at the following edge. A change detected at that same edge still sets its flag.
- R11: A change of the loop bit causes no flag to set in the cycle the routed lines switch over.
- R12: ms_irq is 1 exactly when ms_ie is 1 and at least one flag in msr_rdata[3:0] is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| msr_rd | input | 1 | Status read strobe, clears flags |
| msr_rdata | output | 8 | {DCD, RI, DSR, CTS, dDCD, RI-trailing, dDSR, dCTS} |
| ms_ie | input | 1 | Modem status interrupt enable |
| ms_irq | output | 1 | Modem status interrupt request |
| tx_shift_out | input | 1 | Serial bit from the transmit shifter |
| rx_shift_in | output | 1 | Serial bit to the receive shifter |
| txd_pin | output | 1 | Serial transmit pin |
| rxd_pin | input | 1 | Serial receive pin |
| dtr_n_pin | output | 1 | DTR pin, active low |
| rts_n_pin | output | 1 | RTS pin, active low |
| cts_n_pin | input | 1 | CTS pin, active low |
| dsr_n_pin | input | 1 | DSR pin, active low |
| ri_n_pin | input | 1 | RI pin, active low |
| dcd_n_pin | input | 1 | DCD pin, active low |

## Verification
The bench enters loopback while an external CTS is held asserted. The status line then drops without a real change, and a design lacking the switch-over guard would raise a CTS flag and an interrupt.

It asserts RI and releases it, both externally and through AUX1. This exposes a design that flags both edges, or the leading edge only.

It toggles external pins and rxd_pin during loopback. A leaky mux would let them reach the status or the receiver. It also times the status to the third edge, which catches a synchronizer that is too short or too long.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int REG_W   = 8;
  localparam int CTL_W   = 5;
  localparam int NLINES  = 4;
  localparam int BIT_DTR  = 0;
  localparam int BIT_RTS  = 1;
  localparam int BIT_AUX1 = 2;
  localparam int BIT_AUX2 = 3;
  localparam int BIT_LOOP = 4;

  // bit order matches msr_rdata[7:4]
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;
endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [REG_W-1:0] rdata
);
  localparam int RSVD_W = REG_W - CTL_W;

  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_d = wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    rdata = {{RSVD_W{1'b0}}, ctl_q};
  end

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl_q == $past(wdata[CTL_W-1:0]))); // R2
endmodule

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int                 WIDTH   = 1,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      always_comb stage_d = d;
    end else begin : g_next
      always_comb stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= RST_VAL;
      end else begin
        stage_q[g] <= stage_d;
      end
    end
  end

  always_comb q = stage_q[STAGES-1];
endmodule

// File: rtl/mdm_route.sv
module mdm_route
  import mdm_pkg::*;
(
  input  logic       loop_en,
  input  logic [3:0] ctl_lines,
  input  mdm_lines_t ext_lines,
  input  logic       tx_bit,
  input  logic       rxd_synced,
  output mdm_lines_t lines,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       txd,
  output logic       rx_bit
);
  mdm_lines_t loop_lines;

  always_comb begin
    loop_lines.dsr = ctl_lines[BIT_DTR];
    loop_lines.cts = ctl_lines[BIT_RTS];
    loop_lines.ri  = ctl_lines[BIT_AUX1];
    loop_lines.dcd = ctl_lines[BIT_AUX2];
  end

  always_comb begin
    if (loop_en) begin
      lines  = loop_lines;
      dtr_n  = 1'b1;
      rts_n  = 1'b1;
      txd    = 1'b1;
      rx_bit = tx_bit;
    end else begin
      lines  = ext_lines;
      dtr_n  = ~ctl_lines[BIT_DTR];
      rts_n  = ~ctl_lines[BIT_RTS];
      txd    = tx_bit;
      rx_bit = rxd_synced;
    end
  end
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  mdm_lines_t        lines,
  input  logic              rd_en,
  output mdm_lines_t        stat_q,
  output logic [NLINES-1:0] flag_q
);
  logic              loop_d_q;
  logic              switching;
  logic [NLINES-1:0] raw_set;
  logic [NLINES-1:0] flag_set;
  logic [NLINES-1:0] flag_d;
  logic              stat_ri;

  always_comb begin
    switching  = loop_en ^ loop_d_q;
    raw_set[0] = lines.cts ^ stat_q.cts;
    raw_set[1] = lines.dsr ^ stat_q.dsr;
    raw_set[2] = stat_q.ri & ~lines.ri;
    raw_set[3] = lines.dcd ^ stat_q.dcd;
    flag_set   = switching ? '0 : raw_set;
    flag_d     = (rd_en ? '0 : flag_q) | flag_set;
    stat_ri    = stat_q.ri;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= '0;
      flag_q   <= '0;
      loop_d_q <= 1'b0;
    end else begin
      stat_q   <= lines;
      flag_q   <= flag_d;
      loop_d_q <= loop_en;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && flag_q != '0) |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R9
  AST_RI_TRAILING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[2]) |-> ($past(stat_ri) && !stat_ri)); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && lines == stat_q) |=> (flag_q == '0)); // R10
  AST_NO_SWITCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (switching && flag_q == '0) |=> (flag_q == '0)); // R11
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       msr_rd,
  output logic [7:0] msr_rdata,
  input  logic       ms_ie,
  output logic       ms_irq,
  input  logic       tx_shift_out,
  output logic       rx_shift_in,
  output logic       txd_pin,
  input  logic       rxd_pin,
  output logic       dtr_n_pin,
  output logic       rts_n_pin,
  input  logic       cts_n_pin,
  input  logic       dsr_n_pin,
  input  logic       ri_n_pin,
  input  logic       dcd_n_pin
);
  localparam int SYNC_W = NLINES + 1;

  logic [CTL_W-1:0]  ctl_q;
  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] sync_in;
  mdm_lines_t        ext_lines;
  mdm_lines_t        lines;
  mdm_lines_t        stat_q;
  logic [NLINES-1:0] flag_q;

  mdm_ctl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .wdata (reg_wdata),
    .ctl_q (ctl_q),
    .rdata (ctl_rdata)
  );

  always_comb raw_in = {rxd_pin, dcd_n_pin, ri_n_pin, dsr_n_pin, cts_n_pin};

  mdm_sync #(
    .WIDTH   (SYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({SYNC_W{1'b1}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_in)
  );

  always_comb begin
    ext_lines.cts = ~sync_in[0];
    ext_lines.dsr = ~sync_in[1];
    ext_lines.ri  = ~sync_in[2];
    ext_lines.dcd = ~sync_in[3];
  end

  mdm_route u_route (
    .loop_en    (ctl_q[BIT_LOOP]),
    .ctl_lines  (ctl_q[3:0]),
    .ext_lines  (ext_lines),
    .tx_bit     (tx_shift_out),
    .rxd_synced (sync_in[SYNC_W-1]),
    .lines      (lines),
    .dtr_n      (dtr_n_pin),
    .rts_n      (rts_n_pin),
    .txd        (txd_pin),
    .rx_bit     (rx_shift_in)
  );

  mdm_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .loop_en (ctl_q[BIT_LOOP]),
    .lines   (lines),
    .rd_en   (msr_rd),
    .stat_q  (stat_q),
    .flag_q  (flag_q)
  );

  always_comb begin
    msr_rdata = {stat_q, flag_q};
    ms_irq    = ms_ie & (|flag_q);
  end

  AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[BIT_LOOP]) |=> (txd_pin && dtr_n_pin && rts_n_pin)); // R4
  AST_LOOP_RX_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[BIT_LOOP]) |=> (rx_shift_in == tx_shift_out)); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[7:5] == 3'b000); // R2
endmodule

// File: tb/uart_modem_ctl_bench.sv
module uart_modem_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] ctl_rdata;
  logic       msr_rd;
  logic [7:0] msr_rdata;
  logic       ms_ie;
  logic       ms_irq;
  logic       tx_shift_out;
  logic       rx_shift_in;
  logic       txd_pin;
  logic       rxd_pin;
  logic       dtr_n_pin;
  logic       rts_n_pin;
  logic       cts_n_pin;
  logic       dsr_n_pin;
  logic       ri_n_pin;
  logic       dcd_n_pin;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_modem_ctl u_uart_modem_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .ctl_rdata    (ctl_rdata),
    .msr_rd       (msr_rd),
    .msr_rdata    (msr_rdata),
    .ms_ie        (ms_ie),
    .ms_irq       (ms_irq),
    .tx_shift_out (tx_shift_out),
    .rx_shift_in  (rx_shift_in),
    .txd_pin      (txd_pin),
    .rxd_pin      (rxd_pin),
    .dtr_n_pin    (dtr_n_pin),
    .rts_n_pin    (rts_n_pin),
    .cts_n_pin    (cts_n_pin),
    .dsr_n_pin    (dsr_n_pin),
    .ri_n_pin     (ri_n_pin),
    .dcd_n_pin    (dcd_n_pin)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  bit [4:0] m_mcr;
  bit [4:0] m_p1, m_p2;      // {rxd, dcd_n, ri_n, dsr_n, cts_n} history
  bit [3:0] m_stat, m_flag;  // {dcd, ri, dsr, cts}
  bit       m_loop_prev;

  function automatic bit [3:0] model_lines();
    if (m_mcr[4]) return {m_mcr[3], m_mcr[2], m_mcr[0], m_mcr[1]};
    return ~m_p2[3:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mcr = '0; m_p1 = '1; m_p2 = '1; m_stat = '0; m_flag = '0; m_loop_prev = 1'b0;
    end else begin
      bit [3:0] cur, setv;
      cur = model_lines();
      setv[0] = cur[0] != m_stat[0];
      setv[1] = cur[1] != m_stat[1];
      setv[2] = m_stat[2] && !cur[2];
      setv[3] = cur[3] != m_stat[3];
      if (m_mcr[4] != m_loop_prev) setv = '0;
      m_flag = (msr_rd ? 4'b0 : m_flag) | setv;
      m_stat = cur;
      m_loop_prev = m_mcr[4];
      if (reg_wr) m_mcr = reg_wdata[4:0];
      m_p2 = m_p1;
      m_p1 = {rxd_pin, dcd_n_pin, ri_n_pin, dsr_n_pin, cts_n_pin};
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      bit lp;
      lp = m_mcr[4];
      chk("R2 ctl_rdata", ctl_rdata, {3'b000, m_mcr});
      chk(lp ? "R4 dtr_n_pin" : "R3 dtr_n_pin", {7'd0, dtr_n_pin}, {7'd0, lp ? 1'b1 : ~m_mcr[0]});
      chk(lp ? "R4 rts_n_pin" : "R3 rts_n_pin", {7'd0, rts_n_pin}, {7'd0, lp ? 1'b1 : ~m_mcr[1]});
      chk(lp ? "R4 txd_pin" : "R5 txd_pin", {7'd0, txd_pin}, {7'd0, lp ? 1'b1 : tx_shift_out});
      chk(lp ? "R6 rx_shift_in" : "R5 rx_shift_in", {7'd0, rx_shift_in},
          {7'd0, lp ? tx_shift_out : m_p2[4]});
      chk(lp ? "R8 status lines" : "R7 status lines", {4'd0, msr_rdata[7:4]}, {4'd0, m_stat});
      chk("R9 flags", {4'd0, msr_rdata[3:0]}, {4'd0, m_flag});
      chk("R12 ms_irq", {7'd0, ms_irq}, {7'd0, ms_ie && (m_flag != 0)});
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_clear();
    msr_rd = 1'b1;
    tick();
    msr_rd = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_wdata = 0; msr_rd = 0; ms_ie = 1'b1;
    tx_shift_out = 1'b1; rxd_pin = 1'b1;
    cts_n_pin = 1; dsr_n_pin = 1; ri_n_pin = 1; dcd_n_pin = 1;
    repeat (3) tick();
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 ctl_rdata", ctl_rdata, 8'h00);
    chk("R1 pins", {6'd0, dtr_n_pin, rts_n_pin}, 8'h03);
    chk("R1 msr_rdata", msr_rdata, 8'h00);
    chk("R1 ms_irq", {7'd0, ms_irq}, 8'h00);
    tick();

    // R2 / R3 register and pins
    wr(8'hE3);
    chk("R2 reserved read zero", ctl_rdata, 8'h03);
    chk("R3 dtr/rts low", {6'd0, dtr_n_pin, rts_n_pin}, 8'h00);
    wr(8'h02);
    chk("R3 rts only", {6'd0, dtr_n_pin, rts_n_pin}, 8'h02);

    // R5 serial path normal
    tx_shift_out = 1'b0; #1;
    chk("R5 txd follows", {7'd0, txd_pin}, 8'h00);
    rxd_pin = 1'b0;
    tick();
    chk("R5 rx one edge", {7'd0, rx_shift_in}, 8'h01);
    tick();
    chk("R5 rx two edges", {7'd0, rx_shift_in}, 8'h00);
    rxd_pin = 1'b1; tx_shift_out = 1'b1;

    // R7 timing and R9 flag
    cts_n_pin = 1'b0;
    tick(); tick();
    chk("R7 not yet", {7'd0, msr_rdata[4]}, 8'h00);
    tick();
    chk("R7 cts visible", msr_rdata, 8'h11);
    chk("R12 irq raised", {7'd0, ms_irq}, 8'h01);
    ms_ie = 1'b0; #1;
    chk("R12 irq masked", {7'd0, ms_irq}, 8'h00);
    ms_ie = 1'b1;
    rd_clear();
    chk("R10 cleared", msr_rdata, 8'h10);

    // R9 RI flags trailing edge only
    ri_n_pin = 1'b0;
    repeat (4) tick();
    chk("R9 ri leading no flag", msr_rdata, 8'h50);
    ri_n_pin = 1'b1;
    repeat (3) tick();
    chk("R9 ri trailing flag", msr_rdata, 8'h14);
    rd_clear();

    // R10 change at read edge keeps flag
    dsr_n_pin = 1'b0;
    tick(); tick();
    msr_rd = 1'b1;
    tick();
    msr_rd = 1'b0;
    chk("R10 simultaneous set wins", msr_rdata, 8'h32);
    rd_clear();

    // R11 enter loopback with CTS/DSR asserted externally
    wr(8'h10);
    tick();
    chk("R11 no flag on switch", msr_rdata, 8'h00);
    chk("R4 pins idle", {5'd0, txd_pin, dtr_n_pin, rts_n_pin}, 8'h07);

    // R8 lines from control bits
    wr(8'h1F);
    chk("R4 pins still idle", {5'd0, txd_pin, dtr_n_pin, rts_n_pin}, 8'h07);
    tick();
    chk("R8 looped lines", msr_rdata, 8'hFB);
    rd_clear();
    cts_n_pin = 1'b1; dsr_n_pin = 1'b1; dcd_n_pin = 1'b0; ri_n_pin = 1'b0;
    repeat (4) tick();
    chk("R8 pins ignored", msr_rdata, 8'hF0);
    wr(8'h10);
    tick();
    chk("R9 aux1 trailing", msr_rdata, 8'h0F);
    rd_clear();

    // R6 loop serial path
    rxd_pin = 1'b0; tx_shift_out = 1'b0; #1;
    chk("R6 rx from tx", {6'd0, rx_shift_in, txd_pin}, 8'h01);
    tx_shift_out = 1'b1; #1;
    chk("R6 rx follows tx", {6'd0, rx_shift_in, txd_pin}, 8'h03);
    repeat (3) tick();

    // R11 leave loopback: external DCD/RI now asserted
    wr(8'h00);
    tick();
    chk("R11 no flag on exit", msr_rdata[3:0], 8'h00);
    chk("R7 external back", msr_rdata, 8'hC0);
    rxd_pin = 1'b1; dcd_n_pin = 1'b1; ri_n_pin = 1'b1;
    repeat (4) tick();
    chk("R9 dcd and ri release", msr_rdata, 8'h0C);
    rd_clear();
    tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule